// File: doc/BRIEF.md
# Interrupt Lower-Context Save Engine

This sequencer carries out the opening step of an interrupt service routine. It pops one free context record off a linked list kept in memory, stores the sixteen-word lower register frame into it, and links that record onto the chain of saved contexts. It then writes back the control registers in a single step. Those registers are the link word, the free pointer, the current priority and the global interrupt enable.

A start strobe carries an 8-bit priority operand. The engine reads the register file through a select/data port and drives a single-word memory master with a request/acknowledge handshake. When the operation ends it gives a one-cycle `done_o`, together with either a control write pulse or a trap.

A context pointer is 20 bits wide. Bits 19:16 are the segment and bits 15:0 are the offset. Records are 64-byte aligned.

Top module: `lctx_save`

## Requirements
- R1: If `free_ptr_i` is zero when a supervisor-mode start arrives, `trap_under_o` and `done_o` pulse one cycle later. No memory request is made and `ctl_we_o` stays low.
- R2: If a start arrives with `sup_mode_i` low, `trap_priv_o` and `done_o` pulse one cycle later. There is no memory access, no control write and no underflow trap, even when the pointer is zero.
- R3: The record base byte address is the pointer segment in bits 31:28, zero in bits 27:22, the pointer offset in bits 21:6 and zero in bits 5:0. Frame word k is at base + 4k.
- R4: The first access is a single read of the record base. Bits 19:0 of the returned word become the new free pointer.
- R5: After the read come exactly sixteen writes, for k = 0..15. Their data, in order, is the old `link_i`, then A11, A2, A3, D0, D1, D2, D3, A4, A5, A6, A7, D4, D5, D6, D7. Register n is selected on `rf_sel_o` as {1'b1, n} for an A register and {1'b0, n} for a D register.
- R6: On commit, `link_o` carries the old current priority in bits 31:24 and the old enable in bit 23. Bit 22 is 0, bits 21:20 are kept from the old link, and bits 19:0 hold the old free pointer.
- R7: On commit, `free_ptr_o` holds the read next-pointer, `cur_prio_o` holds the start operand and `irq_en_o` is 1.
- R8: If the original pointer equals `limit_ptr_i`, the operation completes normally and `trap_depl_o` pulses in the commit cycle. Otherwise it stays low.
- R9: `busy_o` is high from the cycle after start until commit. A start seen while busy is ignored. `done_o` is a single-cycle pulse.
- R10: A memory request holds its address, direction and data until acknowledged, so any number of wait states is tolerated.
- R11: All control outputs are committed together with one `ctl_we_o` pulse, which comes one cycle after the last write acknowledge and coincides with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe |
| prio_op_i | input | 8 | New priority operand |
| sup_mode_i | input | 1 | Supervisor mode indication |
| free_ptr_i | input | 20 | Current free-list pointer |
| limit_ptr_i | input | 20 | Low-water limit pointer |
| link_i | input | 32 | Current previous-context link word |
| cur_prio_i | input | 8 | Current priority number |
| irq_en_i | input | 1 | Current global interrupt enable |
| rf_sel_o | output | 5 | Register file select {is_addr, index} |
| rf_data_i | input | 32 | Selected register value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) / read (0) |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation end pulse |
| ctl_we_o | output | 1 | Control register write-back pulse |
| link_o | output | 32 | New link word |
| free_ptr_o | output | 20 | New free pointer |
| cur_prio_o | output | 8 | New current priority |
| irq_en_o | output | 1 | New interrupt enable |
| trap_priv_o | output | 1 | Privilege trap pulse |
| trap_under_o | output | 1 | Empty free-list trap pulse |
| trap_depl_o | output | 1 | Free-list depletion trap pulse |

## Verification
The bench builds the block with its default widths: 32-bit data, 20-bit pointers split 4/16, an 8-bit priority and a 16-word frame. These values put the all-ones pointer within reach, so the segment and offset land at the extremes of the address. They also let the depletion compare, the preserved link bits 21:20 and the 8'hFF and 8'h00 priority edges be reached in a few short runs. The memory responder inserts zero to three wait states per access, which exercises request holding. The directed runs cover the fault orderings and a start that arrives mid-operation.

// File: rtl/lctx_pkg.sv
package lctx_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned PTR_W   = 20;
  localparam int unsigned SEG_W   = 4;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned PRIO_W  = 8;
  localparam int unsigned FRAME_N = 16;
  localparam int unsigned IDX_W   = $clog2(FRAME_N);
  localparam int unsigned RSEL_W  = 5;
  localparam int unsigned PAD_W   = 6;
  localparam int unsigned PP_LSB  = 24;
  localparam int unsigned PIE_BIT = 23;
  localparam int unsigned UL_BIT  = 22;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} seq_st_e;

  // frame slot -> {is_addr, reg index}; slot 0 is the link word
  function automatic logic [RSEL_W-1:0] frame_reg(input logic [IDX_W-1:0] k);
    logic [RSEL_W-1:0] s;
    if (k == 4'd1)       s = {1'b1, 4'd11};
    else if (k <= 4'd3)  s = {1'b1, k};
    else if (k <= 4'd7)  s = {1'b0, 4'(k - 4'd4)};
    else if (k <= 4'd11) s = {1'b1, 4'(k - 4'd4)};
    else                 s = {1'b0, 4'(k - 4'd8)};
    return s;
  endfunction
endpackage

// File: rtl/lctx_addr.sv
module lctx_addr
  import lctx_pkg::*;
(
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] addr_o
);
  localparam int unsigned LOW_W = PAD_W - IDX_W;
  // record base is 64-byte aligned, so the word offset is concatenated
  assign addr_o = {ptr_i[PTR_W-1 -: SEG_W], {PAD_W{1'b0}}, ptr_i[OFF_W-1:0],
                   idx_i, {LOW_W{1'b0}}};
endmodule

// File: rtl/lctx_frame.sv
module lctx_frame
  import lctx_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] link_i,
  input  logic [DATA_W-1:0] rf_data_i,
  output logic [RSEL_W-1:0] rf_sel_o,
  output logic [DATA_W-1:0] wdata_o
);
  assign rf_sel_o = frame_reg(idx_i);
  assign wdata_o  = (idx_i == '0) ? link_i : rf_data_i;
endmodule

// File: rtl/lctx_seq.sv
module lctx_seq
  import lctx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PRIO_W-1:0] prio_op_i,
  input  logic              sup_mode_i,
  input  logic [PTR_W-1:0]  free_ptr_i,
  input  logic [PTR_W-1:0]  limit_ptr_i,
  input  logic [DATA_W-1:0] link_i,
  input  logic [PRIO_W-1:0] cur_prio_i,
  input  logic              irq_en_i,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [DATA_W-1:0] link_snap_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ctl_we_o,
  output logic [DATA_W-1:0] link_o,
  output logic [PTR_W-1:0]  free_ptr_o,
  output logic [PRIO_W-1:0] cur_prio_o,
  output logic              irq_en_o,
  output logic              trap_priv_o,
  output logic              trap_under_o,
  output logic              trap_depl_o
);
  seq_st_e           st_q;
  logic [PTR_W-1:0]  lim_q, nxt_q;
  logic [PRIO_W-1:0] op_q, cp_q;
  logic              ie_q;
  logic              last_w;
  logic              unused_rdata;

  assign unused_rdata = ^mem_rdata_i[DATA_W-1:PTR_W];
  assign last_w    = (idx_o == IDX_W'(FRAME_N - 1));
  assign busy_o    = (st_q != ST_IDLE);
  assign mem_req_o = (st_q != ST_IDLE);
  assign mem_we_o  = (st_q == ST_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  idx_o <= '0;  ptr_o <= '0;  link_snap_o <= '0;
      lim_q <= '0;  nxt_q <= '0;  op_q <= '0;  cp_q <= '0;  ie_q <= 1'b0;
      done_o <= 1'b0;  ctl_we_o <= 1'b0;  link_o <= '0;  free_ptr_o <= '0;
      cur_prio_o <= '0;  irq_en_o <= 1'b0;
      trap_priv_o <= 1'b0;  trap_under_o <= 1'b0;  trap_depl_o <= 1'b0;
    end else begin
      done_o <= 1'b0;  ctl_we_o <= 1'b0;
      trap_priv_o <= 1'b0;  trap_under_o <= 1'b0;  trap_depl_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (!sup_mode_i) begin
            trap_priv_o <= 1'b1;  done_o <= 1'b1;
          end else if (free_ptr_i == '0) begin
            trap_under_o <= 1'b1;  done_o <= 1'b1;
          end else begin
            ptr_o <= free_ptr_i;  lim_q <= limit_ptr_i;  link_snap_o <= link_i;
            op_q <= prio_op_i;  cp_q <= cur_prio_i;  ie_q <= irq_en_i;
            idx_o <= '0;  st_q <= ST_READ;
          end
        end
        ST_READ: if (mem_ack_i) begin
          nxt_q <= mem_rdata_i[PTR_W-1:0];
          st_q  <= ST_WRITE;
        end
        ST_WRITE: if (mem_ack_i) begin
          if (last_w) begin
            link_o <= {cp_q, ie_q, 1'b0, link_snap_o[UL_BIT-1:PTR_W], ptr_o};
            free_ptr_o  <= nxt_q;
            cur_prio_o  <= op_q;
            irq_en_o    <= 1'b1;
            ctl_we_o    <= 1'b1;
            done_o      <= 1'b1;
            trap_depl_o <= (ptr_o == lim_q);
            st_q        <= ST_IDLE;
          end else begin
            idx_o <= idx_o + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_UNDER_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && sup_mode_i && free_ptr_i == '0) |=> (trap_under_o && !mem_req_o && !ctl_we_o)); // R1
  AST_PRIV_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !sup_mode_i) |=> (trap_priv_o && !trap_under_o && !mem_req_o && !ctl_we_o)); // R2
  AST_DEPL_AT_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_depl_o |-> ctl_we_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(idx_o) && $stable(ptr_o))); // R10
  AST_COMMIT_ATOMIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_o |-> (done_o && !mem_req_o && irq_en_o)); // R11
endmodule

// File: rtl/lctx_save.sv
module lctx_save
  import lctx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PRIO_W-1:0] prio_op_i,
  input  logic              sup_mode_i,
  input  logic [PTR_W-1:0]  free_ptr_i,
  input  logic [PTR_W-1:0]  limit_ptr_i,
  input  logic [DATA_W-1:0] link_i,
  input  logic [PRIO_W-1:0] cur_prio_i,
  input  logic              irq_en_i,
  output logic [RSEL_W-1:0] rf_sel_o,
  input  logic [DATA_W-1:0] rf_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ctl_we_o,
  output logic [DATA_W-1:0] link_o,
  output logic [PTR_W-1:0]  free_ptr_o,
  output logic [PRIO_W-1:0] cur_prio_o,
  output logic              irq_en_o,
  output logic              trap_priv_o,
  output logic              trap_under_o,
  output logic              trap_depl_o
);
  logic [IDX_W-1:0]  idx;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] link_snap;

  lctx_seq u_seq (
    .clk_i, .rst_ni, .start_i, .prio_op_i, .sup_mode_i, .free_ptr_i,
    .limit_ptr_i, .link_i, .cur_prio_i, .irq_en_i, .mem_ack_i, .mem_rdata_i,
    .mem_req_o, .mem_we_o, .idx_o(idx), .ptr_o(ptr), .link_snap_o(link_snap),
    .busy_o, .done_o, .ctl_we_o, .link_o, .free_ptr_o, .cur_prio_o, .irq_en_o,
    .trap_priv_o, .trap_under_o, .trap_depl_o
  );

  lctx_addr u_addr (.ptr_i(ptr), .idx_i(mem_we_o ? idx : '0), .addr_o(mem_addr_o));

  lctx_frame u_frame (
    .idx_i(idx), .link_i(link_snap), .rf_data_i,
    .rf_sel_o, .wdata_o(mem_wdata_o)
  );
endmodule

// File: tb/lctx_save_tb_top.sv
module lctx_save_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start, sup, ie_in, mem_ack, busy, done, ctl_we, ie_out;
  logic        tp, tu, td, req, we;
  logic [7:0]  op, cp_in, cp_out;
  logic [19:0] fptr, lim, fptr_out;
  logic [31:0] link_in, link_out, rf_data, addr, wdata, rdata;
  logic [4:0]  rf_sel;

  lctx_save dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .prio_op_i(op), .sup_mode_i(sup),
    .free_ptr_i(fptr), .limit_ptr_i(lim), .link_i(link_in), .cur_prio_i(cp_in),
    .irq_en_i(ie_in), .rf_sel_o(rf_sel), .rf_data_i(rf_data), .mem_req_o(req),
    .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(rdata), .busy_o(busy), .done_o(done), .ctl_we_o(ctl_we),
    .link_o(link_out), .free_ptr_o(fptr_out), .cur_prio_o(cp_out), .irq_en_o(ie_out),
    .trap_priv_o(tp), .trap_under_o(tu), .trap_depl_o(td)
  );

  // register file model: A n = A0A0_00nn, D n = D0D0_00nn
  assign rf_data = rf_sel[4] ? (32'hA0A0_0000 | 32'(rf_sel[3:0]))
                             : (32'hD0D0_0000 | 32'(rf_sel[3:0]));

  // memory responder with programmable wait states
  logic [31:0] nxt_word;
  int          ws, wcnt, wn, rn;
  logic [31:0] w_addr [20];
  logic [31:0] w_data [20];
  logic [31:0] r_addr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; wcnt <= 0; rdata <= '0;
    end else begin
      mem_ack <= 1'b0;
      if (req && !mem_ack) begin
        if (wcnt >= ws) begin
          mem_ack <= 1'b1; wcnt <= 0;
          if (we) begin
            if (wn < 20) begin w_addr[wn] <= addr; w_data[wn] <= wdata; end
            wn <= wn + 1;
          end else begin
            r_addr <= addr; rdata <= nxt_word; rn <= rn + 1;
          end
        end else wcnt <= wcnt + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  typedef struct packed {
    logic        sup; logic [19:0] ptr; logic [19:0] lim; logic [7:0] op;
    logic [7:0]  cp;  logic        ie;  logic [31:0] link; logic [31:0] nxt; logic [1:0] ws;
  } vec_t;
  localparam vec_t VEC [4] = '{
    '{sup:1'b1, ptr:20'h2_0005, lim:20'h0_0001, op:8'h40, cp:8'h10, ie:1'b0, link:32'h0000_0000, nxt:32'hFFF3_1234, ws:2'd0},
    '{sup:1'b1, ptr:20'hF_FFFF, lim:20'hF_FFFF, op:8'hFF, cp:8'h00, ie:1'b1, link:32'h5A3C_1111, nxt:32'h0000_0000, ws:2'd2},
    '{sup:1'b1, ptr:20'h0_0001, lim:20'h0_0002, op:8'h01, cp:8'h7F, ie:1'b1, link:32'hFFFF_FFFF, nxt:32'h0001_0002, ws:2'd1},
    '{sup:1'b1, ptr:20'h8_8000, lim:20'h8_8000, op:8'h80, cp:8'hC3, ie:1'b0, link:32'h0030_0000, nxt:32'h000A_BCDE, ws:2'd3}
  };

  function automatic logic [31:0] exp_word(input int k, input logic [31:0] lk);
    case (k)
      0: return lk;
      1: return 32'hA0A0_000B;
      2, 3: return 32'hA0A0_0000 | 32'(k);
      4, 5, 6, 7: return 32'hD0D0_0000 | 32'(k - 4);
      8, 9, 10, 11: return 32'hA0A0_0000 | 32'(k - 4);
      default: return 32'hD0D0_0000 | 32'(k - 8);
    endcase
  endfunction

  task automatic launch(input vec_t v);
    @(negedge clk);
    sup = v.sup; fptr = v.ptr; lim = v.lim; op = v.op; cp_in = v.cp; ie_in = v.ie;
    link_in = v.link; nxt_word = v.nxt; ws = int'(v.ws); wn = 0; rn = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 500) begin @(negedge clk); t++; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] ea;
    start = 0; sup = 1; fptr = 0; lim = 0; op = 0; cp_in = 0; ie_in = 0;
    link_in = 0; nxt_word = 0; ws = 0; wn = 0; rn = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req && !ctl_we && !tp && !tu && !td, "reset R9", {busy, done, req, ctl_we}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++) begin
      launch(VEC[i]);
      chk(busy && req && !we, "R9 busy/R4 read first", {busy, req, we}, 3'b110);
      wait_done();
      ea = {VEC[i].ptr[19:16], 6'b0, VEC[i].ptr[15:0], 6'b0};
      chk(done && ctl_we, "R11 commit pulse", {done, ctl_we}, 2'b11);
      chk(rn == 1 && r_addr == ea, "R4 R3 read addr", r_addr, ea);
      chk(wn == 16, "R5 write count", wn, 16);
      for (int k = 0; k < 16; k++) begin
        chk(w_addr[k] == ea + 32'(4 * k), "R3 word addr", w_addr[k], ea + 32'(4 * k));
        chk(w_data[k] == exp_word(k, VEC[i].link), "R5 frame data", w_data[k], exp_word(k, VEC[i].link));
      end
      chk(link_out == {VEC[i].cp, VEC[i].ie, 1'b0, VEC[i].link[21:20], VEC[i].ptr}, "R6 link",
          link_out, {VEC[i].cp, VEC[i].ie, 1'b0, VEC[i].link[21:20], VEC[i].ptr});
      chk(fptr_out == VEC[i].nxt[19:0], "R7 free ptr", 32'(fptr_out), 32'(VEC[i].nxt[19:0]));
      chk(cp_out == VEC[i].op && ie_out, "R7 prio/ie", {cp_out, ie_out}, {VEC[i].op, 1'b1});
      chk(td == (VEC[i].ptr == VEC[i].lim), "R8 depletion", td, 32'(VEC[i].ptr == VEC[i].lim));
      chk(!tp && !tu, "R8 no fault traps", {tp, tu}, 0);
      @(negedge clk);
      chk(!done && !ctl_we && !busy, "R9 R11 single pulse", {done, ctl_we, busy}, 0);
    end

    // R1 underflow
    launch('{sup:1'b1, ptr:20'h0, lim:20'h0, op:8'h11, cp:8'h22, ie:1'b0, link:32'h1, nxt:32'h5, ws:2'd0});
    chk(done && tu && !tp && !ctl_we && !req, "R1 underflow trap", {done, tu, tp, ctl_we, req}, 5'b11000);
    repeat (4) @(negedge clk);
    chk(wn == 0 && rn == 0, "R1 no memory access", wn + rn, 0);

    // R2 privilege, also with zero pointer
    launch('{sup:1'b0, ptr:20'h3_0000, lim:20'h0, op:8'h11, cp:8'h22, ie:1'b0, link:32'h1, nxt:32'h5, ws:2'd0});
    chk(done && tp && !tu && !ctl_we && !req, "R2 privilege trap", {done, tp, tu, ctl_we, req}, 5'b11000);
    launch('{sup:1'b0, ptr:20'h0, lim:20'h0, op:8'h11, cp:8'h22, ie:1'b0, link:32'h1, nxt:32'h5, ws:2'd0});
    chk(tp && !tu, "R2 priority over underflow", {tp, tu}, 2'b10);
    repeat (4) @(negedge clk);
    chk(wn == 0 && rn == 0, "R2 no memory access", wn + rn, 0);

    // R9 start while busy is ignored
    launch(VEC[2]);
    repeat (6) @(negedge clk);
    op = 8'h99; fptr = 20'h4_4444; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(wn == 16 && rn == 1, "R9 ignored start access count", wn + rn, 17);
    chk(cp_out == VEC[2].op, "R9 operand from first start", cp_out, VEC[2].op);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      chk(!req && !done, "R9 no second run", {req, done}, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule